// File: doc/BRIEF.md
# Constant Divide-by-Three Shift-Add Unit

This unit divides an unsigned integer by the constant three using only wired shifts, adders and subtractors. It has no multiplier and no iterative divider. The quotient estimate comes from the identity that one third equals one half minus one half of one third. Expanding that identity again and again gives the alternating series x/2 − x/4 + x/8 − x/16 + … . The dividend is widened with guard bits below the binary point. Every term of the series is formed as a right shift, so no term is lost before the shifted value reaches zero. Neighbouring terms are paired into non-negative differences, and the differences are summed. The integer part of that sum is within one of the true quotient.

A second stage finds the exact answer. It forms x − 3·estimate, where three times the estimate is the estimate shifted left once plus itself. It then moves the estimate up or down by one, so the quotient equals floor(x/3) and the remainder falls in 0..2. The unit accepts a new operand on every cycle. The result appears a fixed two cycles later, whatever the operand value. A parameter removes the remainder output, which then reads zero.

Top module: `div3_shiftadd`

## Requirements
- R1: Whenever `out_valid` is high, `out_quot` equals floor(x/3), where x is the `in_data` value that was accepted two cycles earlier.
- R2: With the remainder enabled (the default), `out_rem` is x − 3·`out_quot` whenever `out_valid` is high. It always lies in 0..2.
- R3: `out_valid` is high in a cycle exactly when `in_valid` was high, outside reset, two rising edges earlier. The latency does not depend on the operand value.
- R4: Operands presented on consecutive cycles are all accepted. Each one produces its own result on consecutive cycles, in the order the operands arrived.
- R5: While `rst` is high (synchronous, active high), `out_valid`, `out_quot` and `out_rem` are driven to 0 after the next rising edge.
- R6: In a cycle where `out_valid` is low, `out_quot` and `out_rem` keep the values of the last valid result. Their reset value of 0 counts as such a result. `in_data` presented with `in_valid` low has no effect on the outputs.
- R7: The extreme operands give exact results. These are 0, 1, 2, 3, the largest value 2^DATA_W−1, the values just below it, and exact multiples of three, whose remainder is 0.
- R8: The shift-add series estimate held between the two stages is never more than one away from floor(x/3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_data` as an operand in this cycle |
| in_data | input | DATA_W | Unsigned dividend |
| out_valid | output | 1 | Marks the result outputs as new in this cycle |
| out_quot | output | DATA_W | Quotient floor(x/3) |
| out_rem | output | 2 | Remainder 0..2; zero when the remainder is disabled |

## Verification
The assertions check several properties on every cycle. The two-cycle valid alignment holds. The remainder stays below three. The quotient and remainder rebuild the dividend. The outputs hold while no result is valid. The series estimate stays inside its one-step window. Only the bench's scenarios can show four further points: the exact quotient values against an independent reference, results from back-to-back operand streams arriving in order, the values driven during reset, and the extreme operands near zero and near the top of the range.

// File: rtl/div3_pkg.sv
package div3_pkg;

    localparam int unsigned DIV3_DEF_W = 16;
    localparam int unsigned DIV3_LAT   = 2;

    // Guard bits below the binary point: 2^G must be well above half the term count.
    function automatic int unsigned div3_guard(input int unsigned w);
        return $clog2(w) + 2;
    endfunction

    // Number of alternating terms before the widened operand shifts to zero.
    function automatic int unsigned div3_terms(input int unsigned w);
        return w + div3_guard(w);
    endfunction

endpackage

// File: rtl/div3_series.sv
module div3_series
    import div3_pkg::*;
#(
    parameter int unsigned W = DIV3_DEF_W
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] est
);
    localparam int unsigned G  = div3_guard(W);
    localparam int unsigned XW = W + G;
    localparam int unsigned K  = div3_terms(W);
    localparam int unsigned NP = (K + 1) / 2;

    logic [XW-1:0] xe;
    logic [XW-1:0] term [1:K];
    logic [XW-1:0] pair_d [NP];
    logic [XW-1:0] acc;

    assign xe = {x, {G{1'b0}}};

    // Each series term is a wired right shift of the widened operand.
    for (genvar k = 1; k <= K; k++) begin : g_term
        assign term[k] = xe >> k;
    end

    // Pair a positive term with the following negative one; each difference is non-negative.
    for (genvar p = 0; p < NP; p++) begin : g_pair
        if (2 * p + 2 <= K) begin : g_full
            assign pair_d[p] = term[2*p+1] - term[2*p+2];
        end else begin : g_last
            assign pair_d[p] = term[2*p+1];
        end
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NP; i++) begin
            acc = acc + pair_d[i];
        end
    end

    assign est = acc[XW-1:G];

endmodule

// File: rtl/div3_correct.sv
module div3_correct
    import div3_pkg::*;
#(
    parameter int unsigned W = DIV3_DEF_W
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] est,
    output logic [W-1:0] quot,
    output logic [1:0]   rem
);
    localparam int unsigned RW = W + 3;

    logic [RW-1:0]        est3;
    logic signed [RW-1:0] diff;
    logic signed [RW-1:0] rfix;

    // Three times the estimate, built from a single shift and one add.
    assign est3 = {2'b00, est, 1'b0} + {3'b000, est};
    assign diff = $signed({3'b000, x}) - $signed(est3);

    always_comb begin
        if (diff < 0) begin
            quot = est - 1'b1;
            rfix = diff + RW'(3);
        end else if (diff >= RW'(3)) begin
            quot = est + 1'b1;
            rfix = diff - RW'(3);
        end else begin
            quot = est;
            rfix = diff;
        end
        rem = rfix[1:0];
    end

endmodule

// File: rtl/div3_shiftadd.sv
module div3_shiftadd
    import div3_pkg::*;
#(
    parameter int unsigned DATA_W = DIV3_DEF_W,
    parameter bit          REM_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_quot,
    output logic [1:0]        out_rem
);
    localparam int unsigned CW = DATA_W + 3;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] est;
    } est_stage_t;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] quot;
        logic [1:0]        rem;
    } res_stage_t;

    est_stage_t        sa;
    res_stage_t        sb;
    logic [DATA_W-1:0] est_c;
    logic [DATA_W-1:0] quot_c;
    logic [1:0]        rem_c;

    div3_series #(.W(DATA_W)) u_series (
        .x   (in_data),
        .est (est_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sa <= '0;
        end else begin
            sa.vld <= in_valid;
            if (in_valid) begin
                sa.x   <= in_data;
                sa.est <= est_c;
            end
        end
    end

    div3_correct #(.W(DATA_W)) u_correct (
        .x    (sa.x),
        .est  (sa.est),
        .quot (quot_c),
        .rem  (rem_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sb <= '0;
        end else begin
            sb.vld <= sa.vld;
            if (sa.vld) begin
                sb.quot <= quot_c;
                sb.rem  <= rem_c;
            end
        end
    end

    assign out_valid = sb.vld;
    assign out_quot  = sb.quot;

    if (REM_EN) begin : g_rem
        assign out_rem = sb.rem;

        AST_REM_BELOW_THREE: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_rem < 2'd3)); // R2

        AST_REBUILD_DIVIDEND: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (({3'b000, out_quot} * CW'(3)) + CW'(out_rem) == {3'b000, $past(sa.x)})); // R1
    end else begin : g_norem
        assign out_rem = 2'b00;
    end

    AST_EST_WINDOW: assert property (@(posedge clk) disable iff (rst)
        sa.vld |-> (({3'b000, sa.est} * CW'(3) <= {3'b000, sa.x} + CW'(3)) &&
                    ({3'b000, sa.x} < {3'b000, sa.est} * CW'(3) + CW'(6)))); // R8

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid && !rst, 2)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_quot) && $stable(out_rem))); // R6

endmodule

// File: tb/sim_div3_shiftadd.sv
module sim_div3_shiftadd;
    localparam int unsigned W     = 16;
    localparam time         CLK_P = 10ns;
    localparam int unsigned MAXV  = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [W-1:0] in_data;
    logic         out_valid;
    logic [W-1:0] out_quot;
    logic [1:0]   out_rem;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;

    // Bench-side model of the two-cycle pipe.
    logic         v1 = 1'b0, v2 = 1'b0;
    logic [W-1:0] x1 = '0, x2 = '0;
    string        t1 = "R1", t2 = "R1";
    logic [W-1:0] last_q = '0;
    logic [1:0]   last_r = '0;

    always #(CLK_P / 2) clk = ~clk;

    div3_shiftadd #(.DATA_W(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_quot  (out_quot),
        .out_rem   (out_rem)
    );

    function automatic logic [W-1:0] ref_q(input logic [W-1:0] x);
        return W'(int'(x) / 3);
    endfunction

    function automatic logic [1:0] ref_r(input logic [W-1:0] x);
        return 2'(int'(x) % 3);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: compare outputs against the operand from two edges back.
    task automatic check_outputs();
        chk("R3", "out_valid", int'(out_valid), int'(v2));
        if (v2) begin
            chk(t2, "quotient", int'(out_quot), int'(ref_q(x2)));
            chk(t2 == "R1" ? "R2" : t2, "remainder", int'(out_rem), int'(ref_r(x2)));
            last_q = ref_q(x2);
            last_r = ref_r(x2);
        end else begin
            chk("R6", "held quotient", int'(out_quot), int'(last_q));
            chk("R6", "held remainder", int'(out_rem), int'(last_r));
        end
    endtask

    task automatic step(input logic v, input logic [W-1:0] x, input string tag);
        @(negedge clk);
        check_outputs();
        v2 = v1; x2 = x1; t2 = t1;
        in_valid = v; in_data = x;
        v1 = v; x1 = x; t1 = tag;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; in_valid = 1'b1; in_data = W'(12345);
        repeat (3) @(negedge clk);
        // R5: reset drives zeros even with a valid operand present
        chk("R5", "out_valid in reset", int'(out_valid), 0);
        chk("R5", "quotient in reset", int'(out_quot), 0);
        chk("R5", "remainder in reset", int'(out_rem), 0);
        rst = 1'b0; in_valid = 1'b0; in_data = '0;

        // R7: boundary operands, back to back
        step(1'b1, W'(0), "R7");
        step(1'b1, W'(1), "R7");
        step(1'b1, W'(2), "R7");
        step(1'b1, W'(3), "R7");
        step(1'b1, W'(MAXV), "R7");
        step(1'b1, W'(MAXV - 1), "R7");
        step(1'b1, W'(MAXV - 2), "R7");
        step(1'b1, W'(65532), "R7");
        step(1'b1, W'(3 * 7777), "R7");

        // R6: junk data with in_valid low must not disturb held outputs
        for (int i = 0; i < 6; i++) step(1'b0, W'($urandom), "R6");

        // R4: long back-to-back stream of random operands
        for (int i = 0; i < 400; i++) step(1'b1, W'($urandom), "R4");

        // R1: random valid pattern with gaps
        for (int i = 0; i < 2000; i++) step(1'($urandom % 2), W'($urandom), "R1");

        // R7: all multiples of three in a sweep near the top
        for (int i = 0; i < 30; i++) step(1'b1, W'(MAXV - 3 * i), "R7");

        // Flush the pipe.
        for (int i = 0; i < 4; i++) step(1'b0, W'($urandom), "R6");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule